// File: doc/BRIEF.md
# Accumulator Saturation and Flag Unit

This unit sits at the back end of a fixed-point vector datapath. It takes one wide signed accumulator result per command step and writes it to one of four lanes. Lane 0 is a scalar lane. Lanes 1 to 3 form a three-element vector. For each result the unit does four things. It checks the unshifted value against that lane's accumulator range. It applies an optional arithmetic right shift of twelve bits. It stores the low 32 bits of the shifted value as the lane's accumulator register. It also stores a clamped copy in the lane's 16-bit intermediate register, held sign-extended to 32 bits.

For vector lanes the unit can also turn the stored accumulator into an 8-bit color channel. The channel value is the accumulator shifted right by four and clamped to 0..255. Every out-of-range event sets a sticky bit in a 32-bit status word. A clear strobe marks the start of a new command and empties the status word. The top bit of the word summarises all error bits.

The status word uses this bit layout:

- Bits 3:0 are accumulator overflow, one bit per lane.
- Bits 7:4 are accumulator underflow, one bit per lane.
- Bits 11:8 are intermediate saturation, one bit per lane.
- Bits 14:12 are color saturation for channels 0, 1 and 2.
- Bit 31 is the summary bit.
- All other bits read zero.

Top module: `accsat_unit`

## Requirements
- R1: After reset, every accumulator, intermediate and color register and the whole status word read zero.
- R2: On lane 0, a value above 2^31-1 sets bit 0 and a value below -2^31 sets bit 4. A value exactly at either bound sets neither.
- R3: On lane k (1..3), a value above 2^43-1 sets bit k and a value below -2^43 sets bit 4+k. A value exactly at either bound sets neither.
- R4: The range checks of R2 and R3 use the value before shifting. The stored accumulator is the low 32 bits of the value shifted arithmetically right by 12 when `sf_i` is 1, and by 0 when it is 0.
- R5: On lanes 1..3 the intermediate register is the stored accumulator clamped to -32768..32767. When `lm_i` is 1 the lower bound becomes 0. Any clamp sets bit 8+k.
- R6: On lane 0 the intermediate register is the stored accumulator clamped to 0..4096, whatever `lm_i` is. Any clamp sets bit 8.
- R7: Each intermediate register holds its 16-bit result sign-extended to 32 bits.
- R8: When `color_i` is 1 on lane k in 1..3, color channel k-1 takes the stored accumulator shifted arithmetically right by 4 and clamped to 0..255. A clamp sets bit 12+k-1. On lane 0, `color_i` has no effect.
- R9: A command writes only the selected lane's registers. A cycle without `valid_i` changes no register.
- R10: Status bits are sticky. `clear_i` zeroes them. When `clear_i` and `valid_i` arrive together, the status word holds only the flags of that command.
- R11: Bit 31 of the status word equals the OR of bits 14:0 after every update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Accept one accumulator result this cycle |
| clear_i | input | 1 | Zero the status word (start of command) |
| lane_i | input | 2 | Destination lane, 0 = scalar |
| sf_i | input | 1 | Shift-factor bit: shift by 12 when set |
| lm_i | input | 1 | Limit mode: vector intermediate floor becomes 0 |
| color_i | input | 1 | Also update the color channel of this vector lane |
| acc_i | input | 64 | Wide signed accumulator result |
| acc_o | output | 4x32 | Accumulator registers, lane 0 at [0] |
| ir_o | output | 4x32 | Intermediate registers, sign-extended |
| col_o | output | 3x8 | Color channels 0..2 |
| flag_o | output | 32 | Sticky status word |

## Verification
Clearing the status word and merging a new command's flags can happen in the same cycle. This is the case the bench targets most. It builds a status word from several saturating commands and then issues one more saturating command with `clear_i` raised. The bench expects only that command's bits and a recomputed summary bit. It also issues a clear with no command, and a command with no clear, so that the three outcomes can be told apart. A second overlap has one command raise both an accumulator overflow and an intermediate clamp. Here the range bound and the clamp bound fall in different places on the same value.

// File: rtl/accsat_pkg.sv
package accsat_pkg;

    parameter int ACC_W         = 64;
    parameter int REG_W         = 32;
    parameter int IR_W          = 16;
    parameter int COL_W         = 8;
    parameter int NLANE         = 4;
    parameter int SHIFT_AMT     = 12;
    parameter int COL_SHIFT     = 4;
    parameter int SCALAR_FIT    = 32;
    parameter int VECTOR_FIT    = 44;
    parameter int SCALAR_IR_MAX = 4096;
    parameter int FLAG_W        = 32;

    localparam int NCOL   = NLANE - 1;
    localparam int LANE_W = $clog2(NLANE);
    localparam int VEC_LO = -(1 <<< (IR_W - 1));
    localparam int VEC_HI = (1 <<< (IR_W - 1)) - 1;
    localparam int COL_HI = (1 <<< COL_W) - 1;

    localparam int FL_OVF = 0;
    localparam int FL_UNF = FL_OVF + NLANE;
    localparam int FL_IRS = FL_UNF + NLANE;
    localparam int FL_COL = FL_IRS + NLANE;
    localparam int FL_TOP = FL_COL + NCOL - 1;
    localparam int FL_ERR = FLAG_W - 1;

    typedef struct packed {
        logic             ovf;
        logic             unf;
        logic [REG_W-1:0] ir;
        logic             irsat;
    } lane_res_t;

    typedef struct packed {
        logic [NLANE-1:0][REG_W-1:0] acc;
        logic [NLANE-1:0][REG_W-1:0] ir;
        logic [NCOL-1:0][COL_W-1:0]  col;
        logic [FLAG_W-1:0]           flag;
    } state_t;

endpackage

// File: rtl/accsat_shift.sv
module accsat_shift #(
    parameter int ACC_W     = 64,
    parameter int REG_W     = 32,
    parameter int SHIFT_AMT = 12
) (
    input  logic [ACC_W-1:0] acc_i,
    input  logic             sf_i,
    output logic [REG_W-1:0] mac_o
);
    logic signed [ACC_W-1:0] wide_s;
    logic signed [ACC_W-1:0] shifted_s;

    always_comb begin
        wide_s    = acc_i;
        shifted_s = sf_i ? (wide_s >>> SHIFT_AMT) : wide_s;
        mac_o     = shifted_s[REG_W-1:0];
    end
endmodule

// File: rtl/accsat_clamp.sv
module accsat_clamp #(
    parameter int IN_W     = 32,
    parameter int OUT_W    = 16,
    parameter int LO       = -32768,
    parameter int HI       = 32767,
    parameter bit LM_FLOOR = 1'b1
) (
    input  logic [IN_W-1:0] val_i,
    input  logic            lm_i,
    output logic [IN_W-1:0] val_o,
    output logic            sat_o
);
    localparam logic signed [IN_W-1:0] LO_V = IN_W'(LO);
    localparam logic signed [IN_W-1:0] HI_V = IN_W'(HI);

    logic signed [IN_W-1:0] v_s;
    logic signed [IN_W-1:0] lo_eff;
    logic signed [IN_W-1:0] r_s;

    always_comb begin
        v_s    = val_i;
        lo_eff = (LM_FLOOR && lm_i) ? '0 : LO_V;
        sat_o  = 1'b0;
        r_s    = v_s;
        if (v_s < lo_eff) begin
            r_s   = lo_eff;
            sat_o = 1'b1;
        end else if (v_s > HI_V) begin
            r_s   = HI_V;
            sat_o = 1'b1;
        end
        val_o = {{(IN_W-OUT_W){r_s[OUT_W-1]}}, r_s[OUT_W-1:0]};
    end
endmodule

// File: rtl/accsat_lane.sv
module accsat_lane #(
    parameter int ACC_W    = 64,
    parameter int REG_W    = 32,
    parameter int IR_W     = 16,
    parameter int FIT      = 44,
    parameter int LO       = -32768,
    parameter int HI       = 32767,
    parameter bit LM_FLOOR = 1'b1
) (
    input  logic                  [ACC_W-1:0] acc_i,
    input  logic                  [REG_W-1:0] mac_i,
    input  logic                              lm_i,
    output accsat_pkg::lane_res_t             res_o
);
    localparam int UP_W = ACC_W - FIT + 1;

    logic [UP_W-1:0] upper;
    logic            neg;
    logic [REG_W-1:0] ir_val;
    logic             ir_sat;

    accsat_clamp #(
        .IN_W    (REG_W),
        .OUT_W   (IR_W),
        .LO      (LO),
        .HI      (HI),
        .LM_FLOOR(LM_FLOOR)
    ) u_clamp (
        .val_i(mac_i),
        .lm_i (lm_i),
        .val_o(ir_val),
        .sat_o(ir_sat)
    );

    always_comb begin
        upper       = acc_i[ACC_W-1:FIT-1];
        neg         = acc_i[ACC_W-1];
        res_o.ovf   = !neg && (|upper);
        res_o.unf   = neg && !(&upper);
        res_o.ir    = ir_val;
        res_o.irsat = ir_sat;
    end
endmodule

// File: rtl/accsat_color.sv
module accsat_color #(
    parameter int REG_W     = 32,
    parameter int COL_W     = 8,
    parameter int COL_SHIFT = 4
) (
    input  logic [REG_W-1:0] mac_i,
    output logic [COL_W-1:0] col_o,
    output logic             sat_o
);
    localparam logic signed [REG_W-1:0] TOP_V = REG_W'((1 <<< COL_W) - 1);

    logic signed [REG_W-1:0] v_s;

    always_comb begin
        v_s   = $signed(mac_i) >>> COL_SHIFT;
        sat_o = 1'b0;
        col_o = v_s[COL_W-1:0];
        if (v_s < 0) begin
            col_o = '0;
            sat_o = 1'b1;
        end else if (v_s > TOP_V) begin
            col_o = '1;
            sat_o = 1'b1;
        end
    end
endmodule

// File: rtl/accsat_unit.sv
module accsat_unit
    import accsat_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         valid_i,
    input  logic                         clear_i,
    input  logic [LANE_W-1:0]            lane_i,
    input  logic                         sf_i,
    input  logic                         lm_i,
    input  logic                         color_i,
    input  logic [ACC_W-1:0]             acc_i,
    output logic [NLANE-1:0][REG_W-1:0]  acc_o,
    output logic [NLANE-1:0][REG_W-1:0]  ir_o,
    output logic [NCOL-1:0][COL_W-1:0]   col_o,
    output logic [FLAG_W-1:0]            flag_o
);
    state_t    st_d, st_q;
    lane_res_t res [NLANE];
    logic [REG_W-1:0] mac;
    logic [COL_W-1:0] col_val;
    logic             col_sat;

    accsat_shift #(
        .ACC_W    (ACC_W),
        .REG_W    (REG_W),
        .SHIFT_AMT(SHIFT_AMT)
    ) u_shift (
        .acc_i(acc_i),
        .sf_i (sf_i),
        .mac_o(mac)
    );

    generate
        for (genvar g = 0; g < NLANE; g++) begin : g_lane
            if (g == 0) begin : g_scalar
                accsat_lane #(
                    .ACC_W   (ACC_W),
                    .REG_W   (REG_W),
                    .IR_W    (IR_W),
                    .FIT     (SCALAR_FIT),
                    .LO      (0),
                    .HI      (SCALAR_IR_MAX),
                    .LM_FLOOR(1'b0)
                ) u_lane (
                    .acc_i(acc_i),
                    .mac_i(mac),
                    .lm_i (lm_i),
                    .res_o(res[g])
                );
            end else begin : g_vector
                accsat_lane #(
                    .ACC_W   (ACC_W),
                    .REG_W   (REG_W),
                    .IR_W    (IR_W),
                    .FIT     (VECTOR_FIT),
                    .LO      (VEC_LO),
                    .HI      (VEC_HI),
                    .LM_FLOOR(1'b1)
                ) u_lane (
                    .acc_i(acc_i),
                    .mac_i(mac),
                    .lm_i (lm_i),
                    .res_o(res[g])
                );
            end
        end
    endgenerate

    accsat_color #(
        .REG_W    (REG_W),
        .COL_W    (COL_W),
        .COL_SHIFT(COL_SHIFT)
    ) u_color (
        .mac_i(mac),
        .col_o(col_val),
        .sat_o(col_sat)
    );

    always_comb begin
        lane_res_t          sel;
        logic [FLAG_W-1:0]  nf;
        logic [FLAG_W-1:0]  fl;
        logic [LANE_W-1:0]  ch;
        st_d = st_q;
        sel  = res[lane_i];
        ch   = lane_i - LANE_W'(1);
        nf   = '0;
        if (valid_i) begin
            nf[FL_OVF + int'(lane_i)] = sel.ovf;
            nf[FL_UNF + int'(lane_i)] = sel.unf;
            nf[FL_IRS + int'(lane_i)] = sel.irsat;
            st_d.acc[lane_i] = mac;
            st_d.ir[lane_i]  = sel.ir;
            if (color_i && (lane_i != '0)) begin
                st_d.col[ch]            = col_val;
                nf[FL_COL + int'(ch)]   = col_sat;
            end
        end
        fl         = (clear_i ? '0 : st_q.flag) | nf;
        fl[FL_ERR] = |fl[FL_TOP:0];
        st_d.flag  = fl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc_o  = st_q.acc;
    assign ir_o   = st_q.ir;
    assign col_o  = st_q.col;
    assign flag_o = st_q.flag;

endmodule

// File: rtl/accsat_chk.sv
module accsat_chk
    import accsat_pkg::*;
(
    input logic                        clk,
    input logic                        rst_n,
    input logic                        valid_i,
    input logic                        clear_i,
    input logic [LANE_W-1:0]           lane_i,
    input logic                        sf_i,
    input logic [ACC_W-1:0]            acc_i,
    input logic [NLANE-1:0][REG_W-1:0] acc_o,
    input logic [NLANE-1:0][REG_W-1:0] ir_o,
    input logic [NCOL-1:0][COL_W-1:0]  col_o,
    input logic [FLAG_W-1:0]           flag_o
);
    // R10
    clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i && !valid_i |=> flag_o == '0);

    // R10
    sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_i && !valid_i |=> $stable(flag_o));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> $stable(acc_o) && $stable(ir_o) && $stable(col_o));

    // R9
    other_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && lane_i != 2'd3 |=> acc_o[3] == $past(acc_o[3]));

    // R4
    noshift_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && lane_i == 2'd1 && !sf_i |=> acc_o[1] == $past(acc_i[REG_W-1:0]));

    // R6
    scalar_ir_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ir_o[0][REG_W-1] && (ir_o[0] <= REG_W'(SCALAR_IR_MAX)));

    // R11
    err_summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_o[FL_ERR] == (|flag_o[FL_TOP:0]));

    generate
        for (genvar k = 1; k < NLANE; k++) begin : g_sx
            // R7
            vec_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (ir_o[k][REG_W-1:IR_W-1] == '0) || (ir_o[k][REG_W-1:IR_W-1] == '1));
        end
    endgenerate
endmodule

bind accsat_unit accsat_chk u_chk (.*);

// File: tb/accsat_unit_tb.sv
module accsat_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic        clear_i = 1'b0;
    logic [1:0]  lane_i = '0;
    logic        sf_i = 1'b0;
    logic        lm_i = 1'b0;
    logic        color_i = 1'b0;
    logic [63:0] acc_i = '0;
    logic [3:0][31:0] acc_o;
    logic [3:0][31:0] ir_o;
    logic [2:0][7:0]  col_o;
    logic [31:0]      flag_o;

    int total = 0;
    int bad   = 0;

    typedef struct {
        string            tag;
        logic [3:0][31:0] acc;
        logic [3:0][31:0] ir;
        logic [2:0][7:0]  col;
        logic [31:0]      flag;
    } exp_t;

    exp_t exp_q[$];

    logic [3:0][31:0] m_acc  = '0;
    logic [3:0][31:0] m_ir   = '0;
    logic [2:0][7:0]  m_col  = '0;
    logic [31:0]      m_flag = '0;

    always #2 clk = ~clk;

    accsat_unit u_dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .valid_i(valid_i),
        .clear_i(clear_i),
        .lane_i (lane_i),
        .sf_i   (sf_i),
        .lm_i   (lm_i),
        .color_i(color_i),
        .acc_i  (acc_i),
        .acc_o  (acc_o),
        .ir_o   (ir_o),
        .col_o  (col_o),
        .flag_o (flag_o)
    );

    task automatic check32(input string tag, input string what,
                           input logic [127:0] act, input logic [127:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    // driver: drives one cycle of stimulus and queues the expected state
    task automatic issue(input string tag, input bit v, input bit clr, input int lane,
                         input bit sf, input bit lm, input bit col, input longint a);
        exp_t   e;
        longint sh;
        longint lim;
        int     m, lo, hi, irv, cv;
        logic [31:0] nf;
        @(negedge clk);
        valid_i = v; clear_i = clr; lane_i = 2'(lane); sf_i = sf; lm_i = lm;
        color_i = col; acc_i = a;
        nf = '0;
        if (v) begin
            sh = sf ? (a >>> 12) : a;
            m  = int'(sh[31:0]);
            if (lane == 0) begin
                if (a > 64'sd2147483647) nf[0] = 1'b1;
                else if (a < -64'sd2147483648) nf[4] = 1'b1;
                lo = 0; hi = 4096;
            end else begin
                lim = longint'(1) <<< 43;
                if (a > lim - 1) nf[lane] = 1'b1;
                else if (a < -lim) nf[4 + lane] = 1'b1;
                lo = lm ? 0 : -32768; hi = 32767;
            end
            irv = m;
            if (m < lo) begin irv = lo; nf[8 + lane] = 1'b1; end
            else if (m > hi) begin irv = hi; nf[8 + lane] = 1'b1; end
            m_acc[lane] = m;
            m_ir[lane]  = irv;
            if (col && lane != 0) begin
                cv = m >>> 4;
                if (cv < 0) begin cv = 0; nf[12 + lane - 1] = 1'b1; end
                else if (cv > 255) begin cv = 255; nf[12 + lane - 1] = 1'b1; end
                m_col[lane - 1] = cv[7:0];
            end
        end
        m_flag     = (clr ? 32'h0 : m_flag) | nf;
        m_flag[31] = |m_flag[14:0];
        e.tag = tag; e.acc = m_acc; e.ir = m_ir; e.col = m_col; e.flag = m_flag;
        exp_q.push_back(e);
    endtask

    // monitor: compares one queued item per clock, one ns after the edge
    always @(posedge clk) begin
        #1;
        if (rst_n && exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check32(e.tag, "acc",  128'(acc_o),  128'(e.acc));
            check32(e.tag, "ir",   128'(ir_o),   128'(e.ir));
            check32(e.tag, "col",  128'(col_o),  128'(e.col));
            check32(e.tag, "flag(R11)", 128'(flag_o), 128'(e.flag));
        end
    end

    initial begin
        #400000;
        bad++;
        total++;
        $display("FAIL watchdog expired actual=hang expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        longint big;
        big = longint'(1) <<< 43;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check32("R1", "reset acc",  128'(acc_o),  128'(0));
        check32("R1", "reset ir",   128'(ir_o),   128'(0));
        check32("R1", "reset col",  128'(col_o),  128'(0));
        check32("R1", "reset flag", 128'(flag_o), 128'(0));

        issue("R4 R7 lane1 no shift",         1, 1, 1, 0, 0, 0, 1234);
        issue("R4 R5 lane1 shift clamp high", 1, 1, 1, 1, 0, 0, 64'h12345678);
        issue("R7 lane2 negative",            1, 1, 2, 0, 0, 0, -5000);
        issue("R5 lane2 limit mode floor",    1, 1, 2, 0, 1, 0, -5000);
        issue("R3 lane3 at max",              1, 1, 3, 0, 0, 0, big - 1);
        issue("R3 lane3 over",                1, 1, 3, 0, 0, 0, big);
        issue("R3 lane3 at min",              1, 1, 3, 1, 0, 0, -big);
        issue("R3 lane3 under",               1, 1, 3, 1, 0, 0, -big - 1);
        issue("R2 lane0 at max",              1, 1, 0, 0, 0, 0, 64'sd2147483647);
        issue("R2 lane0 over",                1, 1, 0, 0, 0, 0, 64'sd2147483648);
        issue("R2 lane0 at min",              1, 1, 0, 0, 0, 0, -64'sd2147483648);
        issue("R2 lane0 under",               1, 1, 0, 0, 0, 0, -64'sd2147483649);
        issue("R4 lane0 unshifted check",     1, 1, 0, 1, 0, 0, longint'(1) <<< 32);
        issue("R6 lane0 clamp high",          1, 1, 0, 0, 0, 0, 5000);
        issue("R6 lane0 clamp low lm",        1, 1, 0, 0, 1, 0, -3);
        issue("R6 lane0 in range",            1, 1, 0, 1, 0, 0, 64'h0100_0000);
        issue("R8 channel0 plain",            1, 1, 1, 0, 0, 1, 64'h0A50);
        issue("R8 channel1 sat high",         1, 0, 2, 0, 0, 1, 64'h2000);
        issue("R8 channel2 sat low",          1, 0, 3, 0, 0, 1, -64);
        issue("R8 lane0 color ignored",       1, 0, 0, 0, 0, 1, 64'h0A50);
        issue("R9 idle",                      0, 0, 2, 1, 1, 1, -big * 4);
        issue("R9 lane2 only",                1, 0, 2, 0, 0, 0, 77);
        issue("R10 sticky add",               1, 0, 3, 0, 0, 0, big);
        issue("R10 sticky hold",              0, 0, 0, 0, 0, 0, 0);
        issue("R10 clear with command",       1, 1, 0, 0, 0, 0, 5000);
        issue("R10 clear only",               0, 1, 0, 0, 0, 0, 0);
        issue("R11 color flag only",          1, 0, 1, 0, 0, 1, 64'h7FF0);
        issue("R10 clear with quiet command", 1, 1, 1, 0, 0, 0, 10);

        for (int i = 0; i < 40; i++) begin
            longint a;
            a = (longint'(i) * 64'sh0000_3A5F_1C37) ^ (longint'(i) <<< (i % 48));
            if (i % 3 == 0) a = -a;
            issue("R5 R8 mixed pattern", 1, (i % 5 == 0), i % 4, i[0], i[1], i[2], a);
        end

        @(negedge clk);
        valid_i = 1'b0; clear_i = 1'b0;
        while (exp_q.size() > 0) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule